// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides an unsigned dividend by an unsigned divisor of half its width and returns a quotient and a remainder. It uses the restoring method and produces one quotient bit per clock. The quotient is built inside the register that holds the dividend. Each cycle that register shifts left by one place. The bit leaving its top enters the partial remainder, and the new quotient bit fills the freed bottom position. Two widths are intended: a 32-bit dividend with a 16-bit divisor, and a 48-bit dividend with a 24-bit divisor. Both are chosen through parameters.

A client presents the operands and pulses `start` while the block is idle. After one clock per dividend bit, `done` pulses for one cycle. The quotient and remainder are then valid on the outputs and stay there until the next accepted start. A zero divisor does not run the loop. It completes on the next clock with a flag raised.

Top module: `shiftsub_divider`

## Requirements
- R1: After reset, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor, `done` is high for exactly one cycle. It rises on the DVD_W-th rising edge after the edge that accepted `start` (32 edges for the 32/16 build, 48 for the 48/24 build).
- R3: At `done`, `quotient` holds the full-width unsigned floor of dividend / divisor.
- R4: At `done`, `remainder` holds dividend mod divisor, and it is always smaller than the divisor.
- R5: When the top bit of the partial remainder is 1 before the shift, the subtraction is taken without a compare. Divisors with their top bit set therefore still divide correctly.
- R6: Otherwise the shifted remainder is compared with the divisor from the most significant byte downward, and equality counts as large enough to subtract. For example, dividend equal to divisor gives quotient 1 and remainder 0.
- R7: A zero divisor completes on the first edge after `start`. It sets `div_zero` to 1, drives an all-ones quotient, and places the low DVS_W bits of the dividend on `remainder`.
- R8: A `start` pulse while a division is running is ignored, and the running result is unaffected.
- R9: `quotient`, `remainder` and `div_zero` hold their values after `done` until the next accepted `start`. An accepted start with a nonzero divisor clears `div_zero`.
- R10: A divisor of 1 returns the dividend as the quotient with remainder 0. A dividend smaller than the divisor returns quotient 0 with the dividend as the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | DVD_W | Unsigned dividend |
| divisor | input | DVS_W | Unsigned divisor |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | DVD_W | Quotient, as wide as the dividend |
| remainder | output | DVS_W | Remainder, as wide as the divisor |
| div_zero | output | 1 | Set when the last division had a zero divisor |

## Verification
The bench builds two copies side by side. One uses DVD_W=32 and DVS_W=16, which gives a two-byte compare and a 32-cycle latency. The other uses DVD_W=48 and DVS_W=24, which brings in a three-byte compare chain, cases where the comparison is settled in the middle byte, and a count that has to reach 48. Both copies see the same patterns: maximum divisors that push the overflow bit, divisors whose upper bytes equal the remainder's, and a start pulse injected mid-run.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdiv_state_t;

    function automatic int bytes_for(input int bits);
        return (bits + 7) / 8;
    endfunction

endpackage

// File: rtl/rdiv_bytecmp.sv
// Magnitude compare a >= b, settled by the highest byte that differs.
module rdiv_bytecmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         ge
);
    localparam int NB = rdiv_pkg::bytes_for(W);
    localparam int PW = NB * 8;

    logic [PW-1:0] a_pad;
    logic [PW-1:0] b_pad;
    logic [NB-1:0] byte_gt;
    logic [NB-1:0] byte_eq;

    assign a_pad = PW'(a);
    assign b_pad = PW'(b);

    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_lane
            assign byte_gt[gi] = a_pad[gi*8 +: 8] > b_pad[gi*8 +: 8];
            assign byte_eq[gi] = a_pad[gi*8 +: 8] == b_pad[gi*8 +: 8];
        end
    endgenerate

    // Ascending walk: a higher differing byte overrides any lower verdict.
    always_comb begin
        ge = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (!byte_eq[i]) begin
                ge = byte_gt[i];
            end
        end
    end
endmodule

// File: rtl/rdiv_step.sv
// One restoring iteration: shift, decide, conditionally subtract.
module rdiv_step #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic [DVD_W-1:0] acc_in,
    input  logic [DVS_W-1:0] rem_in,
    input  logic [DVS_W-1:0] dsr_in,
    output logic [DVD_W-1:0] acc_out,
    output logic [DVS_W-1:0] rem_out,
    output logic             take
);
    logic [DVS_W-1:0] rem_sh;
    logic             spill;
    logic             fits;

    assign spill  = rem_in[DVS_W-1];
    assign rem_sh = {rem_in[DVS_W-2:0], acc_in[DVD_W-1]};

    rdiv_bytecmp #(.W(DVS_W)) u_cmp (
        .a  (rem_sh),
        .b  (dsr_in),
        .ge (fits)
    );

    always_comb begin
        take    = spill | fits;
        rem_out = take ? (rem_sh - dsr_in) : rem_sh;
        acc_out = {acc_in[DVD_W-2:0], take};
    end
endmodule

// File: rtl/shiftsub_divider.sv
module shiftsub_divider #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder,
    output logic             div_zero
);
    import rdiv_pkg::*;

    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        rdiv_state_t      st;
        logic [CNT_W-1:0] cnt;
        logic [DVD_W-1:0] acc;
        logic [DVS_W-1:0] rem;
        logic [DVS_W-1:0] dsr;
        logic             done;
        logic             dz;
    } regs_t;

    regs_t r_q, r_d;

    logic [DVD_W-1:0] step_acc;
    logic [DVS_W-1:0] step_rem;
    logic             step_take;

    rdiv_step #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_step (
        .acc_in  (r_q.acc),
        .rem_in  (r_q.rem),
        .dsr_in  (r_q.dsr),
        .acc_out (step_acc),
        .rem_out (step_rem),
        .take    (step_take)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (divisor == '0) begin
                        r_d.acc  = '1;
                        r_d.rem  = dividend[DVS_W-1:0];
                        r_d.dz   = 1'b1;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.acc = dividend;
                        r_d.rem = '0;
                        r_d.dsr = divisor;
                        r_d.cnt = CNT_W'(DVD_W);
                        r_d.dz  = 1'b0;
                        r_d.st  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                r_d.acc = step_acc;
                r_d.rem = step_rem;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, acc: '0, rem: '0, dsr: '0, done: 1'b0, dz: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign quotient  = r_q.acc;
    assign remainder = r_q.rem;
    assign div_zero  = r_q.dz;

    // R6
    byte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (step_take == ({r_q.rem, r_q.acc[DVD_W-1]} >= {1'b0, r_q.dsr})));

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.rem < r_q.dsr));

    // R2
    last_iter_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt == CNT_W'(1)) |=> (done && r_q.st == ST_IDLE));

    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start && divisor == '0) |=> (done && div_zero && quotient == '1));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && start) |=> $stable(r_q.dsr));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

// File: tb/sim_shiftsub_divider.sv
`timescale 1ns/1ps
module sim_shiftsub_divider;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        st0 = 1'b0, st1 = 1'b0;
    logic [31:0] a0 = '0;
    logic [15:0] b0 = '0;
    logic [47:0] a1 = '0;
    logic [23:0] b1 = '0;
    logic        d0, d1, z0, z1;
    logic [31:0] q0;
    logic [15:0] r0;
    logic [47:0] q1;
    logic [23:0] r1;

    int nchk = 0;
    int nfail = 0;

    shiftsub_divider #(.DVD_W(32), .DVS_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(st0), .dividend(a0), .divisor(b0),
        .done(d0), .quotient(q0), .remainder(r0), .div_zero(z0));

    shiftsub_divider #(.DVD_W(48), .DVS_W(24)) u1 (
        .clk(clk), .rst_n(rst_n), .start(st1), .dividend(a1), .divisor(b1),
        .done(d1), .quotient(q1), .remainder(r1), .div_zero(z1));

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_q(input int cfg, input logic [47:0] a, input logic [23:0] b);
        if (b == 0) return (cfg == 0) ? 48'h0000_FFFF_FFFF : 48'hFFFF_FFFF_FFFF;
        return a / {24'd0, b};
    endfunction

    function automatic logic [47:0] exp_r(input int cfg, input logic [47:0] a, input logic [23:0] b);
        if (b == 0) return (cfg == 0) ? {32'd0, a[15:0]} : {24'd0, a[23:0]};
        return a % {24'd0, b};
    endfunction

    task automatic drive(input int cfg, input bit s, input logic [47:0] a, input logic [23:0] b);
        if (cfg == 0) begin st0 = s; a0 = a[31:0]; b0 = b[15:0]; end
        else          begin st1 = s; a1 = a;       b1 = b;       end
    endtask

    // Called at a negedge. Runs one division and checks it.
    task automatic run_op(input int cfg, input logic [47:0] ain, input logic [23:0] bin, input bit intrude);
        int n;
        int first;
        logic [47:0] a, qv, rv, qs, rs, eq, er;
        logic [23:0] b, bx;
        logic dn, dz, dzs;
        n = (cfg == 0) ? 32 : 48;
        a = (cfg == 0) ? {16'd0, ain[31:0]} : ain;
        b = (cfg == 0) ? {8'd0, bin[15:0]} : bin;
        eq = exp_q(cfg, a, b);
        er = exp_r(cfg, a, b);
        first = -1;
        qs = '0; rs = '0; dzs = 1'b0;
        drive(cfg, 1'b1, a, b);
        @(negedge clk);
        drive(cfg, 1'b0, a, b);
        for (int j = 0; j <= n + 2; j++) begin
            dn = (cfg == 0) ? d0 : d1;
            dz = (cfg == 0) ? z0 : z1;
            qv = (cfg == 0) ? {16'd0, q0} : q1;
            rv = (cfg == 0) ? {32'd0, r0} : {24'd0, r1};
            if (dn) begin
                if (first >= 0) chk(1'b0, "R2 second done cycle", 48'(j), 48'(first));
                else begin
                    first = j; qs = qv; rs = rv; dzs = dz;
                end
            end
            if (intrude && j == 5) begin
                bx = ~b;
                if (cfg == 0) bx[23:16] = 8'd0;
                if (bx == 0) bx = 24'd1;
                drive(cfg, 1'b1, ~a, bx);
            end else if (intrude && j == 6) begin
                drive(cfg, 1'b0, a, b);
            end
            if (j == n + 2) begin
                // R9: values held after done
                chk(qv == qs && rv == rs && dz == dzs, "R9 hold after done", qv, qs);
            end
            @(negedge clk);
        end
        chk(first == ((b == 0) ? 0 : n), (b == 0) ? "R7 zero-divisor latency" : "R2 latency",
            48'(first), 48'((b == 0) ? 0 : n));
        chk(qs == eq, (b == 0) ? "R7 quotient" : (intrude ? "R8 quotient" : "R3 quotient"), qs, eq);
        chk(rs == er, (b == 0) ? "R7 remainder" : (intrude ? "R8 remainder" : "R4 remainder"), rs, er);
        chk(dzs == (b == 0), (b == 0) ? "R7 div_zero set" : "R9 div_zero clear", 48'(dzs), 48'(b == 0));
    endtask

    task automatic both(input logic [47:0] a, input logic [23:0] b, input bit intrude);
        run_op(0, a, b, intrude);
        run_op(1, a, b, intrude);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        logic [47:0] ra;
        logic [23:0] rb;
        void'($urandom(32'h5EED_0DD5));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(d0 == 0 && z0 == 0 && q0 == 0 && r0 == 0, "R1 reset 32/16", {16'd0, q0}, 48'd0);
        chk(d1 == 0 && z1 == 0 && q1 == 0 && r1 == 0, "R1 reset 48/24", q1, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);

        both(48'hFFFF_FFFF_FFFF, 24'd1, 1'b0);            // R10 divisor 1
        both(48'h1234_5678_9ABC, 24'hFFFFFF, 1'b0);       // R5 max divisor
        both(48'hFFFF_FFFF_FFFF, 24'hFFFFFF, 1'b0);       // R5
        both(48'd1000, 24'd4000, 1'b0);                   // R10 dividend < divisor
        both(48'h0000_0000_ABCD, 24'h00ABCD, 1'b0);       // R6 equal operands
        both(48'h0101_0101_0101, 24'h010101, 1'b0);       // R6 equal upper bytes
        both(48'hFEDC_BA98_7654, 24'h80FF01, 1'b0);       // R5 top bit of divisor
        both(48'd0, 24'd7, 1'b0);                         // zero dividend
        both(48'hDEAD_BEEF_CAFE, 24'd0, 1'b0);            // R7 zero divisor
        both(48'h0000_0001_0000, 24'h000101, 1'b0);       // R9 flag cleared after zero case
        both(48'h9876_5432_10FE, 24'h00D00D, 1'b1);       // R8 start during run

        for (int k = 0; k < 30; k++) begin
            ra = {$urandom(), $urandom()} [47:0];
            rb = 24'($urandom());
            rb = rb >> ($urandom() % 20);
            if (rb == 0) rb = 24'd3;
            both(ra, rb, 1'b0);
        end

        finish_run();
    end
endmodule